// File: doc/BRIEF.md
# LED Driver Serial Configuration Interface

This block is the serial input side of a sixteen-channel constant-current LED driver. One shift register is fed from a serial data pin on the rising edges of a serial clock. A mode input sets its length. With mode low it is 192 bits and carries a 12-bit brightness word for each channel. With mode high only its low 96 bits are used, and they carry a 6-bit current trim word for each channel. A rising edge on the latch input copies the shifted data into the brightness holding register or the trim holding register. The serial output always shows the top bit of the active shift length, so several drivers can be chained.

After a brightness latch, the shift register is reloaded with a 192-bit status word, which can then be clocked out. The status word carries the per-channel open-LED flags, the thermal error flag and a copy of the trim register. The first brightness latch after a trim load is completed by the next serial clock edge rather than by the latch edge itself. All pins are sampled in the system clock domain, and a signal held high counts as one edge only.

Top module: `led_serial_cfg`

## Requirements
- R1: After reset, `gs_data`, `dc_data` and `sout` are all zero.
- R2: With `mode` low, each rising edge of `sclk` shifts `sin` into bit 0 of a 192-bit register. `sout` shows bit 191, so data clocked in comes out again 192 edges later, MSB first.
- R3: With `mode` low and no completion pending, a rising edge of `xlat` copies the whole register into `gs_data`, where channel n lies in bits [12n+11:12n]. `gs_data` changes at no other time.
- R4: Every brightness update reloads the shift register with the status word. The word has the open-LED flags in bits 15:0 (flag n in bit n), the thermal flag in bit 16, `dc_data` in bits 119:24, and zeros in all other bits. Bit 191 is therefore at once visible on `sout` as 0.
- R5: With `mode` high, only bits 95:0 shift and `sout` shows bit 95. A rising edge of `xlat` copies bits 95:0 into `dc_data`, where channel n lies in bits [6n+5:6n]. The shift register is left as it was, and `gs_data` is untouched.
- R6: After a trim latch, the next brightness `xlat` edge leaves `gs_data` unchanged. The following `sclk` rising edge then updates `gs_data` and reloads the status word. That edge shifts no data.
- R7: Once that completion has happened, later brightness latches take effect at the `xlat` edge again.
- R8: A high level on `sclk` that lasts many system clocks counts as a single shift edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial shift clock, edge-detected |
| sin | input | 1 | Serial data in |
| mode | input | 1 | 0 = brightness (192 bits), 1 = current trim (96 bits) |
| xlat | input | 1 | Latch strobe, edge-detected |
| led_open | input | 16 | Per-channel open-LED flags |
| therm_err | input | 1 | Thermal error flag |
| sout | output | 1 | Serial data out, MSB of active length |
| gs_data | output | 192 | Brightness holding register |
| dc_data | output | 96 | Trim holding register |

## Verification
Each edge of `sclk` or `xlat` is acted on at the first system clock edge after the pin rises. A shift, a latch or a status reload is therefore visible on the outputs one system clock later. The bench drives every pin on the falling clock edge and holds each pulse high for two clocks. It samples results on a later falling edge, and it reads `sout` on the falling edge just before it raises `sclk`. Delayed completion is checked in two steps: `gs_data` is confirmed unchanged after the `xlat` pulse, and then updated after exactly one more `sclk` pulse.

// File: rtl/led_serial_cfg.sv
module led_serial_cfg #(
  parameter int CHANNELS    = 16,
  parameter int GS_BITS     = 12,
  parameter int DC_BITS     = 6,
  parameter int STAT_DC_LSB = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sclk,
  input  logic                         sin,
  input  logic                         mode,
  input  logic                         xlat,
  input  logic [CHANNELS-1:0]          led_open,
  input  logic                         therm_err,
  output logic                         sout,
  output logic [CHANNELS*GS_BITS-1:0]  gs_data,
  output logic [CHANNELS*DC_BITS-1:0]  dc_data
);
  localparam int GSW    = CHANNELS * GS_BITS;
  localparam int DCW    = CHANNELS * DC_BITS;
  localparam int PAD_LO = STAT_DC_LSB - CHANNELS - 1;
  localparam int PAD_HI = GSW - STAT_DC_LSB - DCW;

  logic [GSW-1:0] sr;
  logic           sclk_d, xlat_d, pend, arm;
  logic           sclk_re, xlat_re;
  logic [GSW-1:0] status;

  assign sclk_re = sclk & ~sclk_d;
  assign xlat_re = xlat & ~xlat_d;
  assign status  = {{PAD_HI{1'b0}}, dc_data, {PAD_LO{1'b0}}, therm_err, led_open};
  assign sout    = mode ? sr[DCW-1] : sr[GSW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr      <= '0;
      gs_data <= '0;
      dc_data <= '0;
      sclk_d  <= 1'b0;
      xlat_d  <= 1'b0;
      pend    <= 1'b0;
      arm     <= 1'b0;
    end else begin
      sclk_d <= sclk;
      xlat_d <= xlat;
      if (xlat_re) begin
        if (mode) begin
          dc_data <= sr[DCW-1:0];
          pend    <= 1'b1;
          arm     <= 1'b0;
        end else if (pend) begin
          arm <= 1'b1;
        end else begin
          gs_data <= sr;
          sr      <= status;
        end
      end else if (sclk_re) begin
        if (arm) begin
          gs_data <= sr;
          sr      <= status;
          pend    <= 1'b0;
          arm     <= 1'b0;
        end else if (mode) begin
          sr[DCW-1:0] <= {sr[DCW-2:0], sin};
        end else begin
          sr <= {sr[GSW-2:0], sin};
        end
      end
    end
  end
endmodule

// File: rtl/led_serial_cfg_chk.sv
module led_serial_cfg_chk #(
  parameter int GSW = 192,
  parameter int DCW = 96
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sclk,
  input logic           xlat,
  input logic           mode,
  input logic           sout,
  input logic [GSW-1:0] gs_data,
  input logic [DCW-1:0] dc_data,
  input logic           pend
);
  logic s_d, x_d;
  logic s_re, x_re;
  assign s_re = sclk && !s_d;
  assign x_re = xlat && !x_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_d <= 1'b0;
      x_d <= 1'b0;
    end else begin
      s_d <= sclk;
      x_d <= xlat;
    end
  end

  AST_GS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gs_data) |-> ($past(x_re) || $past(s_re))); // R3
  AST_GS_NOT_IN_DC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gs_data) |-> !$past(x_re && mode)); // R3
  AST_DC_ON_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dc_data) |-> ($past(x_re) && $past(mode))); // R5
  AST_STATUS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(gs_data) && !mode) |-> (sout == 1'b0)); // R4
  AST_PEND_HOLDS_GS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(x_re && !mode && pend) |-> $stable(gs_data)); // R6
  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(x_re && mode)); // R6
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend) |-> ($past(s_re) && !$past(x_re))); // R7
endmodule

bind led_serial_cfg led_serial_cfg_chk #(.GSW(GSW), .DCW(DCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .xlat(xlat), .mode(mode),
  .sout(sout), .gs_data(gs_data), .dc_data(dc_data), .pend(pend)
);

// File: tb/tb_led_serial_cfg.sv
module tb_led_serial_cfg;
  localparam int CLK_PERIOD = 10;
  localparam int GSW = 192;
  localparam int DCW = 96;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sin = 1'b0, mode = 1'b0, xlat = 1'b0, therm_err = 1'b0;
  logic [15:0] led_open = '0;
  logic sout;
  logic [GSW-1:0] gs_data;
  logic [DCW-1:0] dc_data;

  int n_tests = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  led_serial_cfg dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sin(sin), .mode(mode), .xlat(xlat),
    .led_open(led_open), .therm_err(therm_err), .sout(sout),
    .gs_data(gs_data), .dc_data(dc_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [GSW-1:0] gs_pat(input int seed);
    logic [GSW-1:0] v;
    for (int c = 0; c < 16; c++) v[c*12 +: 12] = 12'((c * 37 + seed * 911 + 5) ^ (seed << 4));
    return v;
  endfunction

  function automatic logic [DCW-1:0] dc_pat(input int seed);
    logic [DCW-1:0] v;
    for (int c = 0; c < 16; c++) v[c*6 +: 6] = 6'((c * 11 + seed * 23 + 1) ^ seed);
    return v;
  endfunction

  task automatic check(input string req, input logic [GSW-1:0] act, input logic [GSW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_sclk(input logic d);
    sin = d;
    @(negedge clk) sclk = 1'b1;
    repeat (2) @(negedge clk);
    sclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_xlat();
    @(negedge clk) xlat = 1'b1;
    repeat (2) @(negedge clk);
    xlat = 1'b0;
    @(negedge clk);
  endtask

  task automatic shift_vec(input logic [GSW-1:0] v, input int n, output logic [GSW-1:0] cap);
    cap = '0;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      cap[i] = sout;
      pulse_sclk(v[i]);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 gs_data", gs_data, '0);
    check("R1 dc_data", GSW'(dc_data), '0);
    check("R1 sout", GSW'(sout), '0);
  endtask

  task automatic t_gs_latch();
    logic [GSW-1:0] cap, p;
    p = gs_pat(1);
    mode = 1'b0; led_open = 16'hA5C3; therm_err = 1'b1;
    shift_vec(p, GSW, cap);
    check("R2 sout shows bit 191", GSW'(sout), GSW'(p[GSW-1]));
    check("R3 gs_data before latch", gs_data, '0);
    pulse_xlat();
    check("R3 gs_data after latch", gs_data, p);
    check("R3 channel 5 field", GSW'(gs_data[71:60]), GSW'(p[71:60]));
    check("R4 status MSB on sout", GSW'(sout), '0);
    shift_vec('0, GSW, cap);
    check("R4 status word", cap, {72'b0, 96'b0, 7'b0, 1'b1, 16'hA5C3});
  endtask

  task automatic t_dc_latch();
    logic [GSW-1:0] cap, g;
    logic [DCW-1:0] d;
    d = dc_pat(2); g = gs_data;
    mode = 1'b1;
    shift_vec(GSW'(d), DCW, cap);
    check("R5 sout shows bit 95", GSW'(sout), GSW'(d[DCW-1]));
    pulse_xlat();
    check("R5 dc_data after latch", GSW'(dc_data), GSW'(d));
    check("R5 channel 9 field", GSW'(dc_data[59:54]), GSW'(d[59:54]));
    check("R5 gs_data untouched", gs_data, g);
    shift_vec('0, DCW, cap);
    check("R5 no status reload", cap, GSW'(d));
  endtask

  task automatic t_pending();
    logic [GSW-1:0] cap, p, g;
    p = gs_pat(3); g = gs_data;
    mode = 1'b0;
    shift_vec(p, GSW, cap);
    pulse_xlat();
    check("R6 gs_data held at latch", gs_data, g);
    pulse_sclk(1'b1);
    check("R6 gs_data after extra sclk", gs_data, p);
    check("R6 status MSB after completion", GSW'(sout), '0);
    shift_vec('0, GSW, cap);
    check("R6 status with trim readback", cap, {72'b0, dc_pat(2), 7'b0, 1'b1, 16'hA5C3});
  endtask

  task automatic t_after_completion();
    logic [GSW-1:0] cap, p;
    p = gs_pat(4);
    led_open = 16'h0F0F; therm_err = 1'b0;
    shift_vec(p, GSW, cap);
    pulse_xlat();
    check("R7 immediate latch", gs_data, p);
    shift_vec('0, GSW, cap);
    check("R7 status word", cap, {72'b0, dc_pat(2), 7'b0, 1'b0, 16'h0F0F});
  endtask

  task automatic t_chain();
    logic [GSW-1:0] cap, a, b, g;
    a = gs_pat(5); b = gs_pat(6); g = gs_data;
    shift_vec(a, GSW, cap);
    shift_vec(b, GSW, cap);
    check("R2 chained output", cap, a);
    check("R3 no latch without xlat", gs_data, g);
  endtask

  task automatic t_held_sclk();
    logic [GSW-1:0] cap;
    mode = 1'b1;
    shift_vec('0, DCW, cap);
    sin = 1'b1;
    @(negedge clk) sclk = 1'b1;
    repeat (12) @(negedge clk);
    sclk = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 94; i++) pulse_sclk(1'b0);
    check("R8 one shift after 95 edges", GSW'(sout), '0);
    pulse_sclk(1'b0);
    check("R8 bit reaches top after 96 edges", GSW'(sout), GSW'(1'b1));
    mode = 1'b0;
  endtask

  initial begin
    t_reset();
    t_gs_latch();
    t_dc_latch();
    t_pending();
    t_after_completion();
    t_chain();
    t_held_sclk();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule